// File: doc/BRIEF.md
# Four-Mode Serial Peripheral Master with Per-Transfer Target Select

This block is a synchronous full-duplex serial master for a single shared bus with several peripherals. It alone drives the serial clock and the outbound data line, and it samples the inbound data line. Each peripheral has its own active-low select line. A host starts a transfer with a one-cycle start pulse. With that pulse it supplies the target index, the clock mode, the bit order, the frame length and the transmit word. All of these are latched, so every transfer can use different settings.

While a transfer runs, the chosen select line is held low and the clock makes exactly two edges per bit. Data goes out and comes in on the edges that the mode defines. When the frame is over, the select line returns high. In that same cycle a one-cycle done strobe rises, and the received word appears on the parallel output. The received word is held there until the next transfer completes.

The clock half-period is a build-time parameter counted in system clocks. Frames may be any length from one bit up to the width of the shift word, which is 128 bits by default.

Top module: `spi_xfer_master`

## Requirements
- R1: After reset and whenever no transfer is in progress, every select line is high, busy is low and done is low.
- R2: A transfer drives exactly one select line low: line i (sel_n_o[i]) where i is the target index latched at start. That line stays low, and all others stay high, for the whole transfer.
- R3: The serial clock rests at the CPOL level of the latched mode (mode_i[1]; reset value 0). When select falls it already sits at that level and holds it for DIV system clocks before the first edge.
- R4: A frame of L bits produces exactly 2·L clock edges between select falling and select rising. Every half-period lasts DIV system clocks, and so does the gap from the last edge to select rising.
- R5: Mode encoding is mode_i = {CPOL, CPHA}. With CPHA=0, data is sampled on leading edges (the ones that leave the idle level), and the first bit is on the outbound line before the first edge. With CPHA=1, data is sampled on trailing edges.
- R6: With lsb_first_i=0, bits go out starting at bit L-1 and ending at bit 0. With lsb_first_i=1, they go out starting at bit 0 and ending at bit L-1.
- R7: The frame length is len_m1_i+1, from 1 to 128. Transmit bits at or above L are never sent, and received bits at or above L read as 0.
- R8: The inbound bit captured in frame position p is stored at the same word position as the outbound bit sent in that slot. rx_word_o carries the result in the done cycle and holds it until the next done.
- R9: done_o is high for exactly one cycle: the first cycle in which all select lines are high again after a transfer.
- R10: A start pulse that arrives while busy is ignored. The running transfer keeps its target, length and data, and only one done follows.
- R11: A start pulse applied during the done cycle is accepted, and the new select line is low in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | One-cycle request to begin a transfer |
| tgt_i | input | SEL_W | Index of the peripheral to select |
| mode_i | input | 2 | {CPOL, CPHA} |
| lsb_first_i | input | 1 | 1 selects least-significant-bit-first order |
| len_m1_i | input | LEN_W | Frame length minus one |
| tx_word_i | input | MAX_BITS | Word to transmit |
| rx_word_o | output | MAX_BITS | Word received in the last completed transfer |
| done_o | output | 1 | One-cycle completion strobe |
| busy_o | output | 1 | Transfer in progress |
| sclk_o | output | 1 | Serial clock |
| mosi_o | output | 1 | Outbound serial data |
| miso_i | input | 1 | Inbound serial data |
| sel_n_o | output | N_SEL | Active-low peripheral selects |

## Verification
Two events can share a cycle: the completion of one transfer (select rising, done pulsing, the result word updating) and the acceptance of the next start. The bench provokes this by raising start in the very cycle it first sees done. It then judges three things: the new select line must be low one cycle later, the old result must stay on rx_word_o while the new frame runs, and the new result must be correct once the second done arrives. A second collision, a start during a running frame, is provoked mid-frame with different settings and judged by edge count, select identity and the number of done strobes.

// File: rtl/spi_mst_pkg.sv
package spi_mst_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_LEAD  = 2'd1,
        ST_RUN   = 2'd2,
        ST_TRAIL = 2'd3
    } xfer_state_e;

endpackage

// File: rtl/spi_half_tick.sv
// Half-period timer: pulses tick_o once every DIV cycles while run_i is high.
module spi_half_tick #(
    parameter int DIV = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    output logic tick_o
);
    localparam int DIV_W = (DIV > 1) ? $clog2(DIV) : 1;

    logic [DIV_W-1:0] cnt_d, cnt_q;

    assign tick_o = run_i && (cnt_q == DIV_W'(DIV - 1));

    always_comb begin
        if (!run_i || tick_o) begin
            cnt_d = '0;
        end else begin
            cnt_d = cnt_q + DIV_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end
endmodule

// File: rtl/spi_sel_decode.sv
// Index to active-low one-hot select decode.
module spi_sel_decode #(
    parameter int N_SEL = 4,
    parameter int SEL_W = 2
) (
    input  logic             en_i,
    input  logic [SEL_W-1:0] idx_i,
    output logic [N_SEL-1:0] sel_n_o
);
    for (genvar i = 0; i < N_SEL; i++) begin : g_line
        assign sel_n_o[i] = !(en_i && (idx_i == SEL_W'(i)));
    end
endmodule

// File: rtl/spi_bit_cursor.sv
// Picks the current outbound bit and steps the bit position in either order.
module spi_bit_cursor #(
    parameter int MAX_BITS = 128,
    parameter int LEN_W    = 7
) (
    input  logic [MAX_BITS-1:0] word_i,
    input  logic [LEN_W-1:0]    idx_i,
    input  logic                lsb_i,
    output logic                bit_o,
    output logic [LEN_W-1:0]    nxt_o
);
    assign bit_o = word_i[idx_i];
    assign nxt_o = lsb_i ? (idx_i + LEN_W'(1)) : (idx_i - LEN_W'(1));
endmodule

// File: rtl/spi_xfer_master.sv
module spi_xfer_master
    import spi_mst_pkg::*;
#(
    parameter int N_SEL    = 4,
    parameter int MAX_BITS = 128,
    parameter int DIV      = 2,
    localparam int SEL_W   = (N_SEL > 1) ? $clog2(N_SEL) : 1,
    localparam int LEN_W   = $clog2(MAX_BITS)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start_i,
    input  logic [SEL_W-1:0]    tgt_i,
    input  logic [1:0]          mode_i,
    input  logic                lsb_first_i,
    input  logic [LEN_W-1:0]    len_m1_i,
    input  logic [MAX_BITS-1:0] tx_word_i,
    output logic [MAX_BITS-1:0] rx_word_o,
    output logic                done_o,
    output logic                busy_o,
    output logic                sclk_o,
    output logic                mosi_o,
    input  logic                miso_i,
    output logic [N_SEL-1:0]    sel_n_o
);
    localparam int EDGE_W = LEN_W + 2;

    typedef struct packed {
        xfer_state_e         st;
        logic [EDGE_W-1:0]   edge_n;
        logic [LEN_W-1:0]    idx;
        logic [LEN_W-1:0]    len_m1;
        logic [SEL_W-1:0]    tgt;
        logic                cpol;
        logic                cpha;
        logic                lsb;
        logic                sclk;
        logic                done;
        logic [MAX_BITS-1:0] tx;
        logic [MAX_BITS-1:0] rx_acc;
        logic [MAX_BITS-1:0] rx_out;
    } core_t;

    core_t            q, d;
    logic [N_SEL-1:0] sel_n_d, sel_n_q;
    logic             tick;
    logic             cur_bit;
    logic [LEN_W-1:0] nxt_idx;
    logic             is_last;
    logic             sample_edge;

    spi_half_tick #(.DIV(DIV)) u_tick (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_i  (q.st != ST_IDLE),
        .tick_o (tick)
    );

    spi_bit_cursor #(.MAX_BITS(MAX_BITS), .LEN_W(LEN_W)) u_cursor (
        .word_i (q.tx),
        .idx_i  (q.idx),
        .lsb_i  (q.lsb),
        .bit_o  (cur_bit),
        .nxt_o  (nxt_idx)
    );

    // Select lines come from the next state, so they are registered glitch-free.
    spi_sel_decode #(.N_SEL(N_SEL), .SEL_W(SEL_W)) u_sel (
        .en_i    (d.st != ST_IDLE),
        .idx_i   (d.tgt),
        .sel_n_o (sel_n_d)
    );

    // Edge number 2L-1 ends the frame; {0, len_m1, 1} equals 2*len_m1+1.
    assign is_last     = (q.edge_n == {1'b0, q.len_m1, 1'b1});
    // Even edges are leading edges; CPHA picks which parity samples.
    assign sample_edge = (q.edge_n[0] == q.cpha);

    always_comb begin
        d      = q;
        d.done = 1'b0;
        unique case (q.st)
            ST_IDLE: begin
                if (start_i) begin
                    d.st     = ST_LEAD;
                    d.tgt    = tgt_i;
                    d.cpol   = mode_i[1];
                    d.cpha   = mode_i[0];
                    d.lsb    = lsb_first_i;
                    d.len_m1 = len_m1_i;
                    d.tx     = tx_word_i;
                    d.rx_acc = '0;
                    d.edge_n = '0;
                    d.idx    = lsb_first_i ? '0 : len_m1_i;
                    d.sclk   = mode_i[1];
                end
            end
            ST_LEAD, ST_RUN: begin
                if (tick) begin
                    d.sclk   = ~q.sclk;
                    d.st     = is_last ? ST_TRAIL : ST_RUN;
                    d.edge_n = q.edge_n + EDGE_W'(1);
                    if (sample_edge) begin
                        d.rx_acc[q.idx] = miso_i;
                    end else if (!is_last && (q.edge_n != '0)) begin
                        d.idx = nxt_idx;
                    end
                end
            end
            ST_TRAIL: begin
                if (tick) begin
                    d.st     = ST_IDLE;
                    d.done   = 1'b1;
                    d.rx_out = q.rx_acc;
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q       <= '0;
            q.st    <= ST_IDLE;
            sel_n_q <= '1;
        end else begin
            q       <= d;
            sel_n_q <= sel_n_d;
        end
    end

    assign rx_word_o = q.rx_out;
    assign done_o    = q.done;
    assign busy_o    = (q.st != ST_IDLE);
    assign sclk_o    = q.sclk;
    assign mosi_o    = cur_bit;
    assign sel_n_o   = sel_n_q;
endmodule

// File: rtl/spi_xfer_master_chk.sv
module spi_xfer_master_chk #(
    parameter int N_SEL = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             busy_o,
    input logic             done_o,
    input logic             sclk_o,
    input logic [N_SEL-1:0] sel_n_o
);
    // R1
    idle_sel_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> &sel_n_o);

    // R2
    one_sel_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> ($countones(~sel_n_o) == 1));

    // R2
    sel_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && $past(busy_o)) |-> $stable(sel_n_o));

    // R3
    idle_sclk_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && $past(!busy_o)) |-> $stable(sclk_o));

    // R9
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R9
    done_on_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (&sel_n_o && !$past(&sel_n_o)));
endmodule

bind spi_xfer_master spi_xfer_master_chk #(.N_SEL(N_SEL)) chk_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .busy_o  (busy_o),
    .done_o  (done_o),
    .sclk_o  (sclk_o),
    .sel_n_o (sel_n_o)
);

// File: tb/spi_xfer_master_tb_top.sv
module spi_xfer_master_tb_top;
    localparam int N_SEL = 4;
    localparam int MAXB  = 128;
    localparam int DIV   = 2;

    typedef struct packed {
        logic [1:0]  tgt;
        logic [1:0]  mode;
        logic        lsb;
        logic [6:0]  len_m1;
        logic [31:0] seed;
    } vec_t;

    localparam int NV = 9;
    localparam vec_t VECS [NV] = '{
        '{2'd0, 2'd0, 1'b0, 7'd7,   32'hC3A1_5E72},
        '{2'd1, 2'd1, 1'b0, 7'd15,  32'h1F2E_3D4C},
        '{2'd2, 2'd2, 1'b1, 7'd7,   32'h8BAD_F00D},
        '{2'd3, 2'd3, 1'b1, 7'd31,  32'h0123_4567},
        '{2'd0, 2'd1, 1'b1, 7'd0,   32'hFFFF_FFFE},
        '{2'd1, 2'd2, 1'b0, 7'd127, 32'h5A69_C3E1},
        '{2'd2, 2'd3, 1'b0, 7'd99,  32'h7E57_1DEA},
        '{2'd3, 2'd0, 1'b1, 7'd0,   32'h0000_0001},
        '{2'd0, 2'd3, 1'b0, 7'd1,   32'h2468_ACE0}
    };

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            start_i = 1'b0;
    logic [1:0]      tgt_i = '0;
    logic [1:0]      mode_i = '0;
    logic            lsb_first_i = 1'b0;
    logic [6:0]      len_m1_i = '0;
    logic [MAXB-1:0] tx_word_i = '0;
    logic [MAXB-1:0] rx_word_o;
    logic            done_o, busy_o, sclk_o, mosi_o;
    logic            miso_r = 1'b0;
    logic [N_SEL-1:0] sel_n_o;

    always #5 clk = ~clk;

    spi_xfer_master #(.N_SEL(N_SEL), .MAX_BITS(MAXB), .DIV(DIV)) dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .tgt_i(tgt_i),
        .mode_i(mode_i), .lsb_first_i(lsb_first_i), .len_m1_i(len_m1_i),
        .tx_word_i(tx_word_i), .rx_word_o(rx_word_o), .done_o(done_o),
        .busy_o(busy_o), .sclk_o(sclk_o), .mosi_o(mosi_o), .miso_i(miso_r),
        .sel_n_o(sel_n_o)
    );

    int n_checks = 0;
    int n_fail   = 0;

    // Settings of the frame the peripheral model expects.
    int              cur_len  = 1;
    logic            cur_lsb  = 1'b0;
    logic            cur_cpol = 1'b0;
    logic            cur_cpha = 1'b0;
    logic [MAXB-1:0] cur_resp = '0;

    // Peripheral model and frame monitor, sampled on the falling clock edge.
    int              m_edges, m_gap, m_bad_gap, m_bad_sel, m_kin, m_kout;
    int              m_frames = 0;
    int              m_stray_done = 0;
    logic            m_done_at_end = 1'b0;
    logic            m_sclk_fall = 1'b0;
    logic [N_SEL-1:0] m_sel = '1;
    logic [MAXB-1:0] m_mosi = '0;
    logic            prev_low = 1'b0;
    logic            prev_sclk = 1'b0;
    logic            any_low, lead;
    logic            frame_end;

    function automatic int pos(int k);
        return cur_lsb ? k : (cur_len - 1 - k);
    endfunction

    always @(negedge clk) begin
        any_low   = ~&sel_n_o;
        frame_end = !any_low && prev_low;
        if (rst_n) begin
            if (any_low && !prev_low) begin
                m_edges = 0; m_gap = 0; m_bad_gap = 0; m_bad_sel = 0; m_kin = 0;
                m_sel = sel_n_o; m_sclk_fall = sclk_o; m_mosi = '0;
                if ($countones(~sel_n_o) != 1) m_bad_sel++;
                if (!cur_cpha) begin
                    miso_r = cur_resp[pos(0)];
                    m_kout = 1;
                end else begin
                    m_kout = 0;
                end
            end else if (any_low) begin
                m_gap++;
                if (sel_n_o != m_sel) m_bad_sel++;
                if (sclk_o != prev_sclk) begin
                    m_edges++;
                    if (m_gap != DIV) m_bad_gap++;
                    m_gap = 0;
                    lead = (sclk_o != cur_cpol);
                    if (lead != cur_cpha) begin
                        if (m_kin < cur_len) m_mosi[pos(m_kin)] = mosi_o;
                        m_kin++;
                    end else if (m_kout < cur_len) begin
                        miso_r = cur_resp[pos(m_kout)];
                        m_kout++;
                    end
                end
            end else if (frame_end) begin
                m_gap++;
                if (m_gap != DIV) m_bad_gap++;
                m_done_at_end = done_o;
                m_frames++;
            end
            if (done_o && !frame_end) m_stray_done++;
        end
        prev_low  = any_low;
        prev_sclk = sclk_o;
    end

    task automatic step();
        @(negedge clk);
        #1;
    endtask

    task automatic chk(input logic ok, input string req,
                       input logic [MAXB-1:0] act, input logic [MAXB-1:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [MAXB-1:0] lenmask(int n);
        logic [MAXB-1:0] m = '0;
        for (int i = 0; i < n; i++) m[i] = 1'b1;
        return m;
    endfunction

    function automatic logic [MAXB-1:0] mk_tx(logic [31:0] s);
        return {s, s ^ 32'hA5A5_A5A5, ~s, {s[15:0], s[31:16]}};
    endfunction

    function automatic logic [MAXB-1:0] mk_resp(logic [31:0] s);
        return {s ^ 32'h3C3C_F00F, {s[7:0], s[31:8]}, s + 32'h1357_9BDF, ~{s[15:0], s[31:16]}};
    endfunction

    task automatic launch(input logic [1:0] tgt, input logic [1:0] mode, input logic lsb,
                          input logic [6:0] lm1, input logic [MAXB-1:0] tx,
                          input logic [MAXB-1:0] resp);
        tgt_i = tgt; mode_i = mode; lsb_first_i = lsb; len_m1_i = lm1; tx_word_i = tx;
        cur_len = int'(lm1) + 1; cur_lsb = lsb; cur_cpol = mode[1]; cur_cpha = mode[0];
        cur_resp = resp;
        start_i = 1'b1;
        step();
        start_i = 1'b0;
    endtask

    task automatic wait_done(output logic seen);
        seen = 1'b0;
        for (int i = 0; i < 5000; i++) begin
            if (done_o) begin
                seen = 1'b1;
                break;
            end
            step();
        end
    endtask

    // Called in the done sample: judges the frame the monitor just closed.
    task automatic judge(input logic [1:0] tgt, input int len,
                         input logic [MAXB-1:0] tx, input logic [MAXB-1:0] resp);
        logic [N_SEL-1:0] exp_sel;
        exp_sel = ~(N_SEL'(1) << tgt);
        // R2: single, correct, steady select
        chk((m_sel == exp_sel) && (m_bad_sel == 0), "R2 select line",
            MAXB'(m_sel), MAXB'(exp_sel));
        // R3: idle level at select fall and after the frame
        chk((m_sclk_fall == cur_cpol) && (sclk_o == cur_cpol), "R3 sclk idle level",
            MAXB'({m_sclk_fall, sclk_o}), MAXB'({cur_cpol, cur_cpol}));
        // R4: edge count and half-period timing
        chk((m_edges == 2 * len) && (m_bad_gap == 0), "R4 edge count/timing",
            MAXB'(m_edges), MAXB'(2 * len));
        // R5 R6: data on sample edges, in the chosen order
        chk(m_mosi == (tx & lenmask(len)), "R5/R6 outbound bits",
            m_mosi, tx & lenmask(len));
        // R7 R8: captured bits in place, upper bits zero
        chk(rx_word_o == (resp & lenmask(len)), "R7/R8 received word",
            rx_word_o, resp & lenmask(len));
        // R9: done with selects released
        chk(m_done_at_end && (m_stray_done == 0), "R9 done alignment",
            MAXB'(m_stray_done), '0);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        logic seen;
        logic [MAXB-1:0] tx, rs, first_rx;
        int f0;

        repeat (3) step();
        // R1 R3: reset state
        chk(&sel_n_o, "R1 selects high in reset", MAXB'(sel_n_o), MAXB'(4'hF));
        chk(!busy_o && !done_o, "R1 busy/done low in reset",
            MAXB'({busy_o, done_o}), '0);
        chk(sclk_o == 1'b0, "R3 sclk reset level", MAXB'(sclk_o), '0);
        rst_n = 1'b1;
        repeat (2) step();
        chk(&sel_n_o && !busy_o && !done_o, "R1 idle after reset",
            MAXB'({sel_n_o, busy_o, done_o}), MAXB'(6'b111100));

        for (int v = 0; v < NV; v++) begin
            tx = mk_tx(VECS[v].seed);
            rs = mk_resp(VECS[v].seed);
            launch(VECS[v].tgt, VECS[v].mode, VECS[v].lsb, VECS[v].len_m1, tx, rs);
            wait_done(seen);
            chk(seen, "R9 done seen", MAXB'(seen), MAXB'(1));
            if (seen) judge(VECS[v].tgt, int'(VECS[v].len_m1) + 1, tx, rs);
            repeat (3) step();
        end

        // R10: start while busy is ignored
        f0 = m_frames;
        tx = mk_tx(32'h9E37_79B9);
        rs = mk_resp(32'h9E37_79B9);
        launch(2'd1, 2'd0, 1'b0, 7'd15, tx, rs);
        repeat (10) step();
        tgt_i = 2'd3; mode_i = 2'd3; len_m1_i = 7'd3; tx_word_i = '1; start_i = 1'b1;
        step();
        start_i = 1'b0;
        wait_done(seen);
        if (seen) judge(2'd1, 16, tx, rs);
        repeat (20) step();
        chk((m_frames - f0 == 1) && !busy_o && (&sel_n_o), "R10 start while busy ignored",
            MAXB'(m_frames - f0), MAXB'(1));

        // R11: new start in the done cycle, old result held meanwhile
        tx = mk_tx(32'h0F1E_2D3C);
        rs = mk_resp(32'h0F1E_2D3C);
        launch(2'd2, 2'd1, 1'b1, 7'd11, tx, rs);
        wait_done(seen);
        first_rx = rx_word_o;
        chk(first_rx == (rs & lenmask(12)), "R8 first result", first_rx, rs & lenmask(12));
        tx = mk_tx(32'hDEAD_0B0E);
        rs = mk_resp(32'hDEAD_0B0E);
        launch(2'd3, 2'd2, 1'b0, 7'd9, tx, rs);
        chk(sel_n_o == 4'b0111, "R11 select low right after done",
            MAXB'(sel_n_o), MAXB'(4'b0111));
        repeat (8) step();
        chk(busy_o && (rx_word_o == first_rx), "R8 result held during next frame",
            rx_word_o, first_rx);
        wait_done(seen);
        if (seen) judge(2'd3, 10, tx, rs);
        repeat (4) step();
        chk(&sel_n_o && !busy_o, "R1 idle after back-to-back",
            MAXB'({sel_n_o, busy_o}), MAXB'(5'b11110));

        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule